// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog counter that software controls through one 32-bit control word, written and read over a simple register port. A qualifying reference tick is divided by a selectable prescaler. Each divided tick advances a single counter. When the counter reaches a programmable interval, the block sets an interrupt flag. It then keeps counting, and after a fixed number of further divided ticks it issues a one-clock system-reset request, provided reset generation is enabled.

The interrupt output and the reset request each have their own enable. Both status flags are cleared by writing 1 to them. Clearing the run bit pauses the count without losing it. A self-clearing restart bit puts both counting stages back to zero. After the system reset controller has acted on the request, it pulses an acknowledge input. The block then reloads its default control word but keeps the reset-occurred flag, so software can see why the system restarted.

Control word layout: bits 11:10 prescaler select, bit 7 run, bit 6 interrupt enable, bits 5:4 interval select, bit 3 interrupt flag, bit 2 reset-occurred flag, bit 1 reset enable, bit 0 restart. All other bits read 0 and are ignored on write.

Top module: `wdt_ctrl`

## Requirements
- R1: After power-on reset the control word reads 0x0000_0400, which is prescaler select 1 with every other bit 0, and both irq and rst_req are low.
- R2: Prescaler select value p in bits 11:10 makes one count per 2^PSC_SHp cycles in which ref_tick is high. The defaults give 1, 256, 2048 and 65536. Cycles with ref_tick low do not advance the count.
- R3: With the run bit (bit 7) set and interval select s in bits 5:4, the interrupt flag (bit 3) sets after exactly 2^(INTV_BASE+2s) counts, measured from the restart or enable edge. It is still clear one reference tick earlier.
- R4: Interrupt enable (bit 6) gates only the irq output, and irq is the level of interrupt flag AND interrupt enable. The flag sets at timeout even when bit 6 is 0.
- R5: When reset enable (bit 1) is 1, rst_req pulses high for exactly one clock RST_GAP counts after the interrupt flag sets, whatever the value of bit 6. The reset-occurred flag (bit 2) sets in the same cycle.
- R6: When reset enable is 0, rst_req never asserts and the reset-occurred flag stays 0.
- R7: Clearing the run bit freezes the count at its current value. Setting the bit again resumes from that value, so the total enabled time to the interrupt is unchanged.
- R8: Bits 3 and 2 are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R9: Writing 1 to bit 0 restarts both stages from zero, so a full interval follows the write. Bit 0 always reads 0.
- R10: A one-cycle pulse on sys_rst_done reloads the default control word and keeps the reset-occurred flag, so after a watchdog reset the word reads 0x0000_0404.
- R11: If a write of 1 to the interrupt flag falls in the same cycle as the timeout that sets it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, clears every flag |
| ref_tick | input | 1 | Reference tick qualifier, one count source pulse per high cycle |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| sys_rst_done | input | 1 | Pulse from the system reset controller once its reset has been applied |
| irq | output | 1 | Interrupt level |
| rst_req | output | 1 | One-clock system reset request |

## Verification
Two events can land in the same clock edge. One is the hardware setting of the interrupt flag at timeout. The other is a software write that clears that flag, or a restart write that clears the counter. The bench times a write so that its strobe edge is exactly the timeout edge, counting from a known enable edge. It then judges the result from the control word and irq in the next cycle, where the flag must still be set. The same edge-exact counting is used for the one-tick-early check of every prescaler and interval pair, for pause and resume, and for the single-cycle reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int CTL_W     = 32;
   localparam int B_RESTART = 0;
   localparam int B_RSTEN   = 1;
   localparam int B_RFLAG   = 2;
   localparam int B_IFLAG   = 3;
   localparam int B_ISEL_LO = 4;
   localparam int B_IEN     = 6;
   localparam int B_EN      = 7;
   localparam int B_PSEL_LO = 10;

   typedef enum logic [1:0] {
      PH_INTV = 2'd0,
      PH_GAP  = 2'd1,
      PH_HOLD = 2'd2
   } wdt_phase_e;

   typedef struct packed {
      logic [1:0] psel;
      logic       en;
      logic       ien;
      logic [1:0] isel;
      logic       iflag;
      logic       rflag;
      logic       rsten;
   } wdt_ctl_t;

   localparam wdt_ctl_t CTL_DEFAULT = '{psel: 2'd1, default: '0};

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int SH0 = 0,
   parameter int SH1 = 8,
   parameter int SH2 = 11,
   parameter int SH3 = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic [1:0] psel,
   output logic       tick
);

   localparam int MAX01 = (SH0 > SH1) ? SH0 : SH1;
   localparam int MAX23 = (SH2 > SH3) ? SH2 : SH3;
   localparam int MAXSH = (MAX01 > MAX23) ? MAX01 : MAX23;

   if (SH0 < 0 || SH1 < 0 || SH2 < 0 || SH3 < 0 || MAXSH > 30) begin : g_bad_shift
      $error("wdt_prescale: shift parameters must lie in 0..30");
   end

   if (MAXSH == 0) begin : g_bypass
      logic unused_pre;
      assign unused_pre = ^{clk, rst_n, psel};
      assign tick = run & ~clr;
   end else begin : g_div
      localparam int PW = MAXSH;
      logic [PW-1:0] pcnt_q;
      logic [PW-1:0] lim;
      int            sh;

      always_comb begin
         case (psel)
            2'd0:    sh = SH0;
            2'd1:    sh = SH1;
            2'd2:    sh = SH2;
            default: sh = SH3;
         endcase
         lim = PW'((64'd1 << sh) - 64'd1);
      end

      assign tick = run & ~clr & (pcnt_q >= lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcnt_q <= '0;
         end else if (clr) begin
            pcnt_q <= '0;
         end else if (run) begin
            if (pcnt_q >= lim) pcnt_q <= '0;
            else               pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdt_stage_cnt.sv
module wdt_stage_cnt
   import wdt_pkg::*;
#(
   parameter int INTV_BASE = 14,
   parameter int RST_GAP   = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tick,
   input  logic [1:0] isel,
   output logic       intv_hit,
   output logic       gap_hit
);

   localparam int CW = INTV_BASE + 6;

   if (INTV_BASE < 1 || CW > 60) begin : g_bad_base
      $error("wdt_stage_cnt: INTV_BASE out of range");
   end
   if (RST_GAP < 1 || $clog2(RST_GAP) > CW) begin : g_bad_gap
      $error("wdt_stage_cnt: RST_GAP does not fit the shared counter");
   end

   wdt_phase_e    phase_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic          at_lim;

   // One counter serves both stages; the phase picks the terminal value.
   always_comb begin
      if (phase_q == PH_GAP) lim = CW'(RST_GAP - 1);
      else                   lim = CW'((64'd1 << (INTV_BASE + 2 * int'(isel))) - 64'd1);
   end

   assign at_lim   = tick && (cnt_q >= lim);
   assign intv_hit = at_lim && (phase_q == PH_INTV);
   assign gap_hit  = at_lim && (phase_q == PH_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= PH_INTV;
      end else if (clr) begin
         cnt_q   <= '0;
         phase_q <= PH_INTV;
      end else if (tick && phase_q != PH_HOLD) begin
         if (at_lim) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_INTV) ? PH_GAP : PH_HOLD;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_gap_follows_intv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (intv_hit && !clr) |=> (phase_q == PH_GAP && cnt_q == '0));

endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
   import wdt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTL_W-1:0]  wdata,
   input  logic              sys_rst_done,
   input  logic              intv_hit,
   input  logic              gap_hit,
   output wdt_ctl_t          ctl_q,
   output logic              rst_req
);

   logic unused_wd;
   assign unused_wd = ^{wdata[CTL_W-1:12], wdata[9:8], wdata[B_RESTART]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= CTL_DEFAULT;
         rst_req <= 1'b0;
      end else if (sys_rst_done) begin
         ctl_q   <= '{psel: 2'd1, rflag: ctl_q.rflag, default: '0};
         rst_req <= 1'b0;
      end else begin
         rst_req <= gap_hit & ctl_q.rsten;
         if (wr) begin
            ctl_q.psel  <= wdata[B_PSEL_LO +: 2];
            ctl_q.en    <= wdata[B_EN];
            ctl_q.ien   <= wdata[B_IEN];
            ctl_q.isel  <= wdata[B_ISEL_LO +: 2];
            ctl_q.rsten <= wdata[B_RSTEN];
         end
         // hardware set has priority over a same-cycle software clear
         if (intv_hit)                  ctl_q.iflag <= 1'b1;
         else if (wr && wdata[B_IFLAG]) ctl_q.iflag <= 1'b0;
         if (gap_hit && ctl_q.rsten)    ctl_q.rflag <= 1'b1;
         else if (wr && wdata[B_RFLAG]) ctl_q.rflag <= 1'b0;
      end
   end

   assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (intv_hit && !sys_rst_done) |=> ctl_q.iflag);

   assert_req_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(ctl_q.rsten) && ctl_q.rflag));

   assert_sysrst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_done |=> (ctl_q.psel == 2'd1 && !ctl_q.en && !ctl_q.ien && ctl_q.isel == 2'd0
                        && !ctl_q.iflag && !ctl_q.rsten && ctl_q.rflag == $past(ctl_q.rflag)));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter int PSC_SH0   = 0,
   parameter int PSC_SH1   = 8,
   parameter int PSC_SH2   = 11,
   parameter int PSC_SH3   = 16,
   parameter int INTV_BASE = 14,
   parameter int RST_GAP   = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ref_tick,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        sys_rst_done,
   output logic        irq,
   output logic        rst_req
);

   wdt_ctl_t ctl;
   logic     clr;
   logic     run;
   logic     tick;
   logic     intv_hit;
   logic     gap_hit;

   assign clr = (reg_wr & reg_wdata[B_RESTART]) | sys_rst_done;
   assign run = ctl.en & ref_tick;

   wdt_prescale #(
      .SH0 (PSC_SH0),
      .SH1 (PSC_SH1),
      .SH2 (PSC_SH2),
      .SH3 (PSC_SH3)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .run   (run),
      .psel  (ctl.psel),
      .tick  (tick)
   );

   wdt_stage_cnt #(
      .INTV_BASE (INTV_BASE),
      .RST_GAP   (RST_GAP)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .tick     (tick),
      .isel     (ctl.isel),
      .intv_hit (intv_hit),
      .gap_hit  (gap_hit)
   );

   wdt_ctl_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (reg_wr),
      .wdata        (reg_wdata),
      .sys_rst_done (sys_rst_done),
      .intv_hit     (intv_hit),
      .gap_hit      (gap_hit),
      .ctl_q        (ctl),
      .rst_req      (rst_req)
   );

   assign reg_rdata = {20'd0, ctl.psel, 2'b00, ctl.en, ctl.ien, ctl.isel,
                       ctl.iflag, ctl.rflag, ctl.rsten, 1'b0};
   assign irq       = ctl.iflag & ctl.ien;

   assert_pause_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.en && !clr) |=> $stable(u_cnt.cnt_q));

endmodule

// File: tb/tb_wdt_ctrl.sv
`timescale 1ns/1ps
module tb_wdt_ctrl;

   localparam int IB  = 2;
   localparam int GAP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b1;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        sys_rst_done = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        rst_req;

   wdt_ctrl #(
      .PSC_SH0 (0), .PSC_SH1 (1), .PSC_SH2 (2), .PSC_SH3 (3),
      .INTV_BASE (IB), .RST_GAP (GAP)
   ) dut (
      .clk (clk), .rst_n (rst_n), .ref_tick (ref_tick), .reg_wr (reg_wr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .sys_rst_done (sys_rst_done),
      .irq (irq), .rst_req (rst_req)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          due;
      logic [31:0] rd;
      logic        irq;
      logic        rq;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   saw_rq = 1'b0;
   bit   done = 1'b0;

   always @(negedge clk) if (rst_req) saw_rq = 1'b1;

   // monitor: pops due items and compares them with the outputs
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         exp_t e;
         e = sbq.pop_front();
         n_chk++;
         if (e.due != cyc || reg_rdata !== e.rd || irq !== e.irq || rst_req !== e.rq) begin
            n_err++;
            $display("FAIL %s @%0d: rdata=%h irq=%b req=%b expected rdata=%h irq=%b req=%b",
                     e.tag, e.due, reg_rdata, irq, rst_req, e.rd, e.irq, e.rq);
         end
      end
   end

   function automatic logic [31:0] cw(int p, bit en, bit ie, int s, bit re);
      return (32'(p) << 10) | (32'(en) << 7) | (32'(ie) << 6) | (32'(s) << 4) | (32'(re) << 1);
   endfunction

   task automatic expect_in(int k, logic [31:0] rd, logic i, logic q, string tag);
      exp_t e;
      int   idx;
      e.due = cyc + k; e.rd = rd; e.irq = i; e.rq = q; e.tag = tag;
      idx = sbq.size();
      for (int j = 0; j < sbq.size(); j++) begin
         if (sbq[j].due > e.due) begin idx = j; break; end
      end
      sbq.insert(idx, e);
   endtask

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic drain();
      while (sbq.size() > 0) @(negedge clk);
   endtask

   task automatic por();
      rst_n = 1'b0; ref_tick = 1'b1; sys_rst_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; saw_rq = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] c, c2;
      int c0, p;
      @(negedge clk);
      por();
      // R1 reset state
      chk(reg_rdata == 32'h400 && !irq && !rst_req, "R1 reset word", reg_rdata, 32'h400);
      // R9 restart reads 0, R8 W1C on clear flags is harmless
      wr(32'h40D);
      chk(reg_rdata == 32'h400, "R9 restart bit reads 0", reg_rdata, 32'h400);

      // R2/R3 every prescaler and interval pair
      for (int ps = 0; ps < 4; ps++) begin
         for (int s = 0; s < 4; s++) begin
            int t;
            por();
            c = cw(ps, 1, 1, s, 0);
            t = (4 << (2 * s)) * (1 << ps);
            wr(c | 32'h1);
            expect_in(t - 1, c, 1'b0, 1'b0, "R3 not one tick early");
            expect_in(t, c | 32'h8, 1'b1, 1'b0, "R2 R3 timeout");
            drain();
         end
      end

      // R2 ref_tick low holds the count
      por();
      ref_tick = 1'b0;
      c = cw(1, 1, 1, 0, 0);
      wr(c | 32'h1);
      repeat (20) @(negedge clk);
      chk(reg_rdata == c, "R2 no count without ref_tick", reg_rdata, c);
      ref_tick = 1'b1;
      expect_in(7, c, 1'b0, 1'b0, "R2 gated early");
      expect_in(8, c | 32'h8, 1'b1, 1'b0, "R2 gated timeout");
      drain();

      // R4 flag without irq, R6 no reset when disabled, R8 write-0 keeps flag
      por();
      c = cw(0, 1, 0, 0, 0);
      wr(c | 32'h1);
      expect_in(4, c | 32'h8, 1'b0, 1'b0, "R4 flag sets irq masked");
      drain();
      c2 = cw(0, 1, 1, 0, 0);
      wr(c2);
      chk(reg_rdata == (c2 | 32'h8) && irq, "R4 R8 irq level after enable", reg_rdata, c2 | 32'h8);
      repeat (40) @(negedge clk);
      chk(!saw_rq && reg_rdata == (c2 | 32'h8), "R6 no reset request", {31'd0, saw_rq}, 32'd0);
      wr(c2 | 32'h8);
      chk(reg_rdata == c2 && !irq, "R8 W1C interrupt flag", reg_rdata, c2);

      // R5 reset with irq masked, R10 acknowledge keeps flag
      por();
      c = cw(0, 1, 0, 0, 1);
      wr(c | 32'h1);
      expect_in(4, c | 32'h8, 1'b0, 1'b0, "R5 interrupt stage");
      expect_in(4 + GAP - 1, c | 32'h8, 1'b0, 1'b0, "R5 before request");
      expect_in(4 + GAP, c | 32'hC, 1'b0, 1'b1, "R5 request pulse");
      expect_in(4 + GAP + 1, c | 32'hC, 1'b0, 1'b0, "R5 pulse one cycle");
      drain();
      sys_rst_done = 1'b1;
      @(posedge clk); @(negedge clk);
      sys_rst_done = 1'b0;
      chk(reg_rdata == 32'h404 && !irq && !rst_req, "R10 defaults with flag kept", reg_rdata, 32'h404);
      wr(32'h404);
      chk(reg_rdata == 32'h400, "R8 W1C reset flag", reg_rdata, 32'h400);

      // R7 pause and resume
      por();
      c = cw(0, 1, 1, 1, 0);
      wr(c | 32'h1);
      c0 = cyc;
      repeat (5) @(negedge clk);
      wr(c & ~32'h80);
      p = cyc - c0;
      repeat (50) @(negedge clk);
      chk(reg_rdata == (c & ~32'h80) && !irq, "R7 frozen while paused", reg_rdata, c & ~32'h80);
      wr(c);
      expect_in(16 - p - 1, c, 1'b0, 1'b0, "R7 resume early");
      expect_in(16 - p, c | 32'h8, 1'b1, 1'b0, "R7 resume timeout");
      drain();

      // R9 restart mid-interval
      por();
      c = cw(0, 1, 1, 1, 0);
      wr(c | 32'h1);
      repeat (9) @(negedge clk);
      wr(c | 32'h1);
      chk(reg_rdata == c, "R9 restart reads 0", reg_rdata, c);
      expect_in(15, c, 1'b0, 1'b0, "R9 full interval early");
      expect_in(16, c | 32'h8, 1'b1, 1'b0, "R9 full interval");
      drain();

      // R11 clear write on the timeout edge
      por();
      c = cw(0, 1, 1, 0, 0);
      wr(c | 32'h1);
      repeat (3) @(negedge clk);
      wr(c | 32'h8);
      chk(reg_rdata == (c | 32'h8) && irq, "R11 set wins over clear", reg_rdata, c | 32'h8);
      wr(c | 32'h8);
      chk(reg_rdata == c && !irq, "R11 later clear works", reg_rdata, c);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule